// File: doc/BRIEF.md
# Push-Pull Two-Wire Serial Engine

This block is the bit-level master for a point-to-point, two-wire bus on which a single slave hangs. Both lines are driven actively in both directions, so there are no pull-ups, no acknowledge bits and no device address. A front-end supplies an 8-bit register address, a direction bit, a byte count and up to eight write bytes, then pulses `start`. The engine builds the frame on its own. It sends a start condition and the register address, then either shifts out the write bytes or turns the data line around and collects the read bytes. Every byte is followed by an even parity bit. A stop condition closes the frame, and the engine reports `done` or `err` for one cycle.

Bus timing comes from a programmable divider. One bit slot lasts `div_val` input cycles, and a value of 0 or 1 counts as 2. The clock is low for the first half of the slot and high for the second. A programmable delay sets how many input cycles after the falling clock edge the data line takes its new value. An `abort` input drops any frame at once: the lines return to their idle-high state and `err` is raised.

The controller is a state machine with six states: IDLE, START, ADDR, WDATA, RDATA and STOP. Its transitions are:
- IDLE→START on an accepted `start`.
- START→ADDR at the end of the start slot.
- ADDR→WDATA or ADDR→RDATA after the address parity slot, chosen by the latched direction.
- WDATA→STOP or RDATA→STOP after the parity slot of the last byte.
- STOP→IDLE at the end of the stop slot.
- Any busy state→IDLE on `abort`.

Top module: `pushpull_link_master`

## Requirements
- R1: While idle and during reset, `busy` is 0 and `scl_o`, `sda_o` and `sda_oe` are all 1; `done` and `err` are 0.
- R2: `start` is accepted only while idle. In the cycle after acceptance the START slot begins: `scl_o` stays 1 for the whole slot, and `sda_o` is 1 for the first L cycles and 0 for the rest, where L is defined in R3. A `start` while busy has no effect on the frame.
- R3: A slot lasts P = max(div_val, 2) cycles. Its cycles are numbered 0 to P-1, `scl_o` is 0 in cycles 0 to L-1 with L = P - floor(P/2), and 1 after. `div_val`, `out_dly`, `reg_addr`, `rd_nwr`, `len_m1` and `wdata` are latched on acceptance, and later changes are ignored until the frame ends.
- R4: In a driven slot after START, `sda_o` keeps the previous slot's final value in cycles below D and shows the slot's bit from cycle D on, where D = min(out_dly, L-1).
- R5: After START come nine ADDR slots: the eight bits of `reg_addr`, MSB first, then an even parity bit equal to the XOR of those eight bits. No device address and no acknowledge slot exist anywhere in the frame.
- R6: On a write (`rd_nwr`=0), `len_m1`+1 bytes follow the address. Byte i is taken from `wdata[8i+7:8i]` in order of rising i, and each byte is sent as eight bits MSB first plus an even parity bit.
- R7: On a read (`rd_nwr`=1), the frame has 9·(`len_m1`+1) RDATA slots straight after the address parity slot. In each of them `sda_oe` is 0 and `sda_o` is 1, and `sda_i` is sampled in slot cycle L. Received byte i, MSB first, lands in `rdata[8i+7:8i]`. `rdata` is cleared to 0 on every acceptance.
- R8: One STOP slot drives a 0 bit, following the R4 timing. After a read the line is driven to 0 from the first STOP cycle. The next cycle is idle with `done`=1 for exactly one cycle.
- R9: If a received parity bit differs from the XOR of its received byte, the closing cycle shows `err`=1 and `done`=0. `done` and `err` are never 1 together.
- R10: `abort` while busy makes the next cycle idle (R1 lines) with `err`=1 for one cycle. `abort` while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame (taken only when idle) |
| abort | input | 1 | Drop the current frame |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| reg_addr | input | 8 | Slave register address |
| len_m1 | input | LEN_W (3) | Byte count minus one |
| wdata | input | 8<<LEN_W (64) | Write bytes, byte i at [8i+7:8i] |
| div_val | input | DIV_W (8) | Input cycles per bit slot |
| out_dly | input | DLY_W (3) | Data change delay after clock falls |
| sda_i | input | 1 | Sampled data line |
| scl_o | output | 1 | Bus clock |
| sda_o | output | 1 | Data line value |
| sda_oe | output | 1 | Data line drive enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse: frame completed cleanly |
| err | output | 1 | One-cycle pulse: parity error or abort |
| rdata | output | 8<<LEN_W (64) | Received bytes |

## Verification
A wrong state or slot counter shows up quickly at the pins. The bench compares `scl_o`, `sda_o`, `sda_oe`, `busy`, `done` and `err` against its own waveform in every cycle, so a shifted slot edge, a misplaced data change or a missing turnaround is caught in the very cycle it first appears. A wrong bit or byte index shows up as a wrong data value on the line within one slot on writes. On reads it shows up in `rdata` or as a false parity error when the frame closes. A stuck busy state or a lost abort is seen in the cycle after the triggering edge.

// File: rtl/pp_link_pkg.sv
package pp_link_pkg;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_START,
        LK_ADDR,
        LK_WDATA,
        LK_RDATA,
        LK_STOP
    } lk_state_e;

    // index of the parity slot inside a 9-slot byte
    localparam logic [3:0] PAR_SLOT = 4'd8;

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/pp_bit_timer.sv
module pp_bit_timer #(
    parameter int DIV_W = 8,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    input  logic [DLY_W-1:0] dly_in,
    output logic             scl_hi,
    output logic             chg,
    output logic             samp,
    output logic             slot_end
);
    logic [DIV_W-1:0] per_q, low_q, chg_q, cnt_q;
    logic [DIV_W-1:0] per_n, low_n, dly_ext;

    always_comb begin
        per_n   = (div_in < DIV_W'(2)) ? DIV_W'(2) : div_in;
        low_n   = per_n - (per_n >> 1);
        dly_ext = DIV_W'(dly_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= DIV_W'(2);
            low_q <= DIV_W'(1);
            chg_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            per_q <= per_n;
            low_q <= low_n;
            chg_q <= (dly_ext < low_n) ? dly_ext : (low_n - DIV_W'(1));
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= slot_end ? '0 : (cnt_q + DIV_W'(1));
        end
    end

    assign slot_end = (cnt_q == (per_q - DIV_W'(1)));
    assign scl_hi   = (cnt_q >= low_q);
    assign chg      = (cnt_q >= chg_q);
    assign samp     = (cnt_q == low_q);
endmodule

// File: rtl/pp_tx_bit.sv
module pp_tx_bit #(
    parameter int LEN_W = 3
) (
    input  logic                  use_addr,
    input  logic                  force_zero,
    input  logic [7:0]            addr,
    input  logic [(8<<LEN_W)-1:0] wbytes,
    input  logic [LEN_W-1:0]      byte_idx,
    input  logic [3:0]            bit_idx,
    output logic                  bit_out
);
    import pp_link_pkg::*;

    logic [7:0] cur;

    always_comb begin
        cur = use_addr ? addr : wbytes[{byte_idx, 3'b000} +: 8];
        if (force_zero)
            bit_out = 1'b0;
        else if (bit_idx == PAR_SLOT)
            bit_out = even_par(cur);
        else
            bit_out = cur[3'd7 - bit_idx[2:0]];
    end
endmodule

// File: rtl/pp_rx_collect.sv
module pp_rx_collect #(
    parameter int LEN_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  sample_en,
    input  logic [LEN_W-1:0]      byte_idx,
    input  logic [3:0]            bit_idx,
    input  logic                  line_in,
    output logic [(8<<LEN_W)-1:0] rbytes,
    output logic                  par_err
);
    import pp_link_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbytes  <= '0;
            par_err <= 1'b0;
        end else if (clear) begin
            rbytes  <= '0;
            par_err <= 1'b0;
        end else if (sample_en) begin
            if (bit_idx == PAR_SLOT) begin
                if (line_in != even_par(rbytes[{byte_idx, 3'b000} +: 8]))
                    par_err <= 1'b1;
            end else begin
                rbytes[{byte_idx, 3'd7 - bit_idx[2:0]}] <= line_in;
            end
        end
    end
endmodule

// File: rtl/pushpull_link_master.sv
module pushpull_link_master #(
    parameter int DIV_W = 8,
    parameter int DLY_W = 3,
    parameter int LEN_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  abort,
    input  logic                  rd_nwr,
    input  logic [7:0]            reg_addr,
    input  logic [LEN_W-1:0]      len_m1,
    input  logic [(8<<LEN_W)-1:0] wdata,
    input  logic [DIV_W-1:0]      div_val,
    input  logic [DLY_W-1:0]      out_dly,
    input  logic                  sda_i,
    output logic                  scl_o,
    output logic                  sda_o,
    output logic                  sda_oe,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic [(8<<LEN_W)-1:0] rdata
);
    import pp_link_pkg::*;

    localparam int DATA_W = 8 << LEN_W;

    lk_state_e         state_q, state_n;
    logic [3:0]        bit_q;
    logic [LEN_W-1:0]  byte_q, len_q;
    logic [7:0]        addr_q;
    logic [DATA_W-1:0] wd_q;
    logic              rd_q, prev_q, done_q, err_q;

    logic scl_hi, chg, samp, slot_end;
    logic tx_bit, perr;
    logic accept, abort_hit, last_bit;

    assign accept    = start && (state_q == LK_IDLE);
    assign abort_hit = abort && (state_q != LK_IDLE);
    assign last_bit  = (bit_q == PAR_SLOT);

    pp_bit_timer #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .run      (state_q != LK_IDLE),
        .div_in   (div_val),
        .dly_in   (out_dly),
        .scl_hi   (scl_hi),
        .chg      (chg),
        .samp     (samp),
        .slot_end (slot_end)
    );

    pp_tx_bit #(.LEN_W(LEN_W)) u_tx (
        .use_addr   (state_q == LK_ADDR),
        .force_zero (state_q == LK_STOP),
        .addr       (addr_q),
        .wbytes     (wd_q),
        .byte_idx   (byte_q),
        .bit_idx    (bit_q),
        .bit_out    (tx_bit)
    );

    pp_rx_collect #(.LEN_W(LEN_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample_en ((state_q == LK_RDATA) && samp),
        .byte_idx  (byte_q),
        .bit_idx   (bit_q),
        .line_in   (sda_i),
        .rbytes    (rdata),
        .par_err   (perr)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        if (abort_hit) begin
            state_n = LK_IDLE;
        end else begin
            unique case (state_q)
                LK_IDLE:  if (start) state_n = LK_START;
                LK_START: if (slot_end) state_n = LK_ADDR;
                LK_ADDR:  if (slot_end && last_bit)
                              state_n = rd_q ? LK_RDATA : LK_WDATA;
                LK_WDATA,
                LK_RDATA: if (slot_end && last_bit && (byte_q == len_q))
                              state_n = LK_STOP;
                LK_STOP:  if (slot_end) state_n = LK_IDLE;
                default:  state_n = LK_IDLE;
            endcase
        end
    end

    // state register, slot counters and result pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            bit_q   <= '0;
            byte_q  <= '0;
            len_q   <= '0;
            addr_q  <= '0;
            wd_q    <= '0;
            rd_q    <= 1'b0;
            prev_q  <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            if (accept) begin
                addr_q <= reg_addr;
                wd_q   <= wdata;
                rd_q   <= rd_nwr;
                len_q  <= len_m1;
                bit_q  <= '0;
                byte_q <= '0;
            end
            if (abort_hit) begin
                err_q <= 1'b1;
            end else if (slot_end) begin
                unique case (state_q)
                    LK_START: prev_q <= 1'b0;
                    LK_ADDR, LK_WDATA: begin
                        prev_q <= tx_bit;
                        if (last_bit) begin
                            bit_q <= '0;
                            if (state_q == LK_WDATA) byte_q <= byte_q + 1'b1;
                        end else begin
                            bit_q <= bit_q + 4'd1;
                        end
                    end
                    LK_RDATA: begin
                        prev_q <= 1'b0;
                        if (last_bit) begin
                            bit_q  <= '0;
                            byte_q <= byte_q + 1'b1;
                        end else begin
                            bit_q <= bit_q + 4'd1;
                        end
                    end
                    LK_STOP: begin
                        prev_q <= 1'b0;
                        done_q <= !perr;
                        err_q  <= perr;
                    end
                    default: prev_q <= prev_q;
                endcase
            end
        end
    end

    // pin outputs
    always_comb begin
        unique case (state_q)
            LK_IDLE: begin
                scl_o = 1'b1; sda_o = 1'b1; sda_oe = 1'b1;
            end
            LK_START: begin
                scl_o = 1'b1; sda_o = !scl_hi; sda_oe = 1'b1;
            end
            LK_RDATA: begin
                scl_o = scl_hi; sda_o = 1'b1; sda_oe = 1'b0;
            end
            default: begin
                scl_o = scl_hi; sda_o = chg ? tx_bit : prev_q; sda_oe = 1'b1;
            end
        endcase
    end

    assign busy = (state_q != LK_IDLE);
    assign done = done_q;
    assign err  = err_q;
endmodule

// File: rtl/pp_link_checker.sv
module pp_link_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic abort,
    input logic busy,
    input logic done,
    input logic err,
    input logic scl_o,
    input logic sda_o,
    input logic sda_oe
);
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o && sda_oe));

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R4/R2: with the clock held high inside a frame the line may only fall (start condition)
    assert_data_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && scl_o && $past(scl_o) && sda_oe && $past(sda_oe)
         && (sda_o != $past(sda_o))) |-> !sda_o);

    assert_release_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_oe |-> busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && err));
endmodule

bind pushpull_link_master pp_link_checker u_link_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .abort  (abort),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .scl_o  (scl_o),
    .sda_o  (sda_o),
    .sda_oe (sda_oe)
);

// File: tb/tb_pushpull_link_master.sv
module tb_pushpull_link_master;
    localparam int LEN_W = 3;
    localparam int DW    = 8 << LEN_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, start, abort, rd_nwr, sda_i;
    logic [7:0] reg_addr, div_val;
    logic [LEN_W-1:0] len_m1;
    logic [2:0] out_dly;
    logic [DW-1:0] wdata, rdata;
    logic scl_o, sda_o, sda_oe, busy, done, err;

    pushpull_link_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .rd_nwr(rd_nwr), .reg_addr(reg_addr), .len_m1(len_m1), .wdata(wdata),
        .div_val(div_val), .out_dly(out_dly), .sda_i(sda_i),
        .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe), .busy(busy),
        .done(done), .err(err), .rdata(rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    // expected pin waveform: {scl, sda, oe, busy, done, err}
    logic [5:0] exp_q[$];
    logic       sdi_q[$];
    string      tag_q[$];

    int   m_lo, m_d, m_p;
    logic m_prev;

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp<=%0d", cyc_cnt, 150000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(string t, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", t, act, expv, $time);
        end
    endtask

    task automatic push(logic [5:0] e, logic s, string t);
        exp_q.push_back(e);
        sdi_q.push_back(s);
        tag_q.push_back(t);
    endtask

    task automatic step();
        logic [5:0] e;
        logic s;
        string t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            s = sdi_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = 6'b111000;
            s = 1'b1;
            t = "R1";
        end
        sda_i = s;
        chk(t, 64'({scl_o, sda_o, sda_oe, busy, done, err}), 64'(e));
    endtask

    task automatic tx_slot(logic b, string t);
        for (int c = 0; c < m_p; c++)
            push({(c >= m_lo), ((c >= m_d) ? b : m_prev), 1'b1, 1'b1, 2'b00},
                 1'b1, {t, " R3 R4"});
        m_prev = b;
    endtask

    task automatic rx_slot(logic b);
        for (int c = 0; c < m_p; c++)
            push({(c >= m_lo), 1'b1, 1'b0, 1'b1, 2'b00}, b, "R7");
        m_prev = 1'b0;
    endtask

    task automatic tx_byte(logic [7:0] v, string t);
        for (int i = 7; i >= 0; i--) tx_slot(v[i], t);
        tx_slot(^v, t);
    endtask

    task automatic rx_byte(logic [7:0] v, logic flip);
        for (int i = 7; i >= 0; i--) rx_slot(v[i]);
        rx_slot((^v) ^ flip);
    endtask

    // build the whole expected frame from the requirements
    task automatic plan_frame(logic rd, logic [7:0] a, int nb, logic [DW-1:0] wd,
                              logic [DW-1:0] rb, logic [7:0] bad, int dv, int dl,
                              output logic [DW-1:0] er);
        logic perr;
        perr = 1'b0;
        er   = '0;
        m_p  = (dv < 2) ? 2 : dv;
        m_lo = m_p - m_p / 2;
        m_d  = (dl < m_lo) ? dl : m_lo - 1;
        for (int c = 0; c < m_p; c++)
            push({1'b1, (c < m_lo), 1'b1, 1'b1, 2'b00}, 1'b1, "R2");
        m_prev = 1'b0;
        tx_byte(a, "R5");
        for (int i = 0; i < nb; i++) begin
            if (rd) begin
                rx_byte(rb[8*i +: 8], bad[i]);
                er[8*i +: 8] = rb[8*i +: 8];
                if (bad[i]) perr = 1'b1;
            end else begin
                tx_byte(wd[8*i +: 8], "R6");
            end
        end
        tx_slot(1'b0, "R8");
        push({1'b1, 1'b1, 1'b1, 1'b0, !perr, perr}, 1'b1, perr ? "R9" : "R8");
    endtask

    task automatic run_frame(logic rd, logic [7:0] a, int nb, logic [DW-1:0] wd,
                             logic [DW-1:0] rb, logic [7:0] bad, int dv, int dl,
                             int poke_at);
        logic [DW-1:0] er;
        int k;
        plan_frame(rd, a, nb, wd, rb, bad, dv, dl, er);
        rd_nwr = rd; reg_addr = a; len_m1 = LEN_W'(nb - 1); wdata = wd;
        div_val = 8'(dv); out_dly = 3'(dl);
        start = 1'b1;
        step();
        start = 1'b0;
        k = 0;
        while (exp_q.size() > 0) begin
            if (k == poke_at) begin
                // R2/R3: new start and changed inputs mid-frame must not disturb it
                start = 1'b1; div_val = 8'd9; out_dly = 3'd6;
                reg_addr = ~a; wdata = ~wd; len_m1 = ~len_m1; rd_nwr = ~rd;
            end
            step();
            start = 1'b0;
            k++;
        end
        chk(rd ? "R7 rdata" : "R7 rdata cleared on write", 64'(rdata), 64'(er));
        step();
    endtask

    initial begin
        logic [DW-1:0] er;
        rst_n = 1'b0; start = 1'b0; abort = 1'b0; rd_nwr = 1'b0; sda_i = 1'b1;
        reg_addr = '0; div_val = 8'd4; out_dly = 3'd1; len_m1 = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset lines", 64'({scl_o, sda_o, sda_oe, busy, done, err}), 64'(6'b111000));
        chk("R1 reset rdata", 64'(rdata), 64'd0);
        rst_n = 1'b1;
        step();

        // single write byte
        run_frame(1'b0, 8'hA5, 1, 64'h3C, '0, 8'h00, 4, 1, -1);
        // three write bytes, delay clamped below the low phase
        run_frame(1'b0, 8'h12, 3, 64'h00_F0_0F_81, '0, 8'h00, 5, 7, -1);
        // two read bytes at the fastest rate
        run_frame(1'b1, 8'h40, 2, '0, 64'h7E_81, 8'h00, 2, 0, -1);
        // eight write bytes, divider 0 treated as 2, mid-frame poke ignored
        run_frame(1'b0, 8'hC3, 8, 64'h0123_4567_89AB_CDEF, '0, 8'h00, 0, 1, 30);
        // eight read bytes
        run_frame(1'b1, 8'h07, 8, '0, 64'hFEDC_BA98_7654_3210, 8'h00, 7, 3, -1);
        // read with a bad parity bit on byte 1
        run_frame(1'b1, 8'h99, 3, '0, 64'h55_AA_01, 8'h02, 3, 2, -1);

        // abort mid-read
        plan_frame(1'b1, 8'h33, 4, '0, 64'h11223344, 8'h00, 4, 1, er);
        rd_nwr = 1'b1; reg_addr = 8'h33; len_m1 = 3'd3; div_val = 8'd4; out_dly = 3'd1;
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (50) step();
        abort = 1'b1;
        exp_q.delete(); sdi_q.delete(); tag_q.delete();
        push(6'b111001, 1'b1, "R10 abort");
        step();
        abort = 1'b0;
        push(6'b111000, 1'b1, "R10 after abort");
        step();

        // abort while idle is ignored
        abort = 1'b1;
        push(6'b111000, 1'b1, "R10 idle abort");
        step();
        abort = 1'b0;
        push(6'b111000, 1'b1, "R10 idle abort");
        step();

        // recovery, slow clock
        run_frame(1'b0, 8'h5A, 2, 64'hBEEF, '0, 8'h00, 255, 5, -1);
        // one read byte with divider 1 treated as 2
        run_frame(1'b1, 8'hE1, 1, '0, 64'hC6, 8'h00, 1, 4, -1);

        repeat (3) step();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule